// File: doc/BRIEF.md
# Software Interrupt Fan-Out Unit

This unit turns one software interrupt request into a series of per-CPU "mark pending" commands. A request is a 64-bit word plus the index of the CPU that issued it. The unit walks a parameterised table of CPUs, one entry per clock. Each entry is a 32-bit affinity value. For every CPU the request selects, the unit offers a command (CPU index, interrupt number) on a valid/ready output. The storage that holds pending state sits downstream and is not part of this block.

There are two ways to pick targets. In targeted mode, the upper three affinity levels of a CPU must equal the ones in the request, and the request's 16-bit target list must have the bit set that the CPU's level-0 affinity points to. The unit clears each served bit from a working copy of the list and stops as soon as that copy is empty. In broadcast mode, every CPU except the sender is chosen and the target list plays no part. A one-cycle done pulse closes every request.

Top module: `sgi_fanout`

## Requirements
- R1: Request word fields are: interrupt number at bits [27:24], target list at [15:0], affinity level 1 at [23:16], level 2 at [39:32], level 3 at [55:48], and the broadcast bit at 40. Every command carries the requested interrupt number on `cmd_intid`.
- R2: In targeted mode (bit 40 clear), a CPU whose affinity is {L3[31:24], L2[23:16], L1[15:8], L0[7:0]} is chosen only if L3/L2/L1 equal the request's fields, L0 is below 16, and target-list bit L0 is still set. CPUs are offered in ascending index order.
- R3: In targeted mode, each accepted command clears the chosen CPU's level-0 bit from the working target list, so a given list bit produces at most one command.
- R4: In targeted mode, the scan ends as soon as the working list becomes zero. CPUs with higher indices are then not visited.
- R5: In broadcast mode (bit 40 set), every CPU except `req_cpu` receives one command, whatever the target list holds.
- R6: The unit visits one CPU per clock. While `cmd_valid` is high and `cmd_ready` is low, the command and the scan position are held unchanged.
- R7: A request is taken only when the unit is idle (`busy` low). Requests presented while busy have no effect.
- R8: A targeted request that matches no CPU scans the whole table and ends with no command. A targeted request whose list is zero ends at once with no command.
- R9: `done` is high for exactly one cycle after the last CPU visit or the early stop. In the following cycle the unit is idle.
- R10: After reset the unit is idle, with `cmd_valid`, `done` and `busy` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present (taken only while idle) |
| req_word | input | 64 | Request word, fields per R1 |
| req_cpu | input | IDX_W | Index of the requesting CPU |
| cpu_aff | input | NUM_CPUS*32 | Affinity of CPU i at bits [32*i+31:32*i] |
| cmd_valid | output | 1 | Pending command offered |
| cmd_ready | input | 1 | Downstream accepts the command |
| cmd_cpu | output | IDX_W | Target CPU index of the command |
| cmd_intid | output | 4 | Interrupt number of the command |
| done | output | 1 | One-cycle end-of-request pulse |
| busy | output | 1 | A request is being processed |

## Verification
Properties inside the controller are checked on every clock. They cover four points: a stalled command stays steady, the sender is never a broadcast target, a served list bit is gone in the next cycle, and a targeted scan never runs with an empty list. They also check that `done` is a single pulse and that the latched request stays frozen while the unit is busy. The scenarios have to establish the rest: the exact set and order of targets, the number of cycles up to the early stop, the full scan when nothing matches, and how requests injected mid-scan are dropped. A behavioural model in the bench predicts these and compares against the design on every clock.

// File: rtl/sgi_fanout_pkg.sv
package sgi_fanout_pkg;

   localparam int unsigned REQ_W       = 64;
   localparam int unsigned AFF_W       = 32;
   localparam int unsigned LVL_W       = 8;
   localparam int unsigned UPPER_W     = AFF_W - LVL_W;
   localparam int unsigned TLIST_W     = 16;
   localparam int unsigned TLIST_IDX_W = $clog2(TLIST_W);
   localparam int unsigned INTID_W     = 4;

   // request word field positions
   localparam int unsigned TLIST_LSB = 0;
   localparam int unsigned AFF1_LSB  = 16;
   localparam int unsigned INTID_LSB = 24;
   localparam int unsigned AFF2_LSB  = 32;
   localparam int unsigned MODE_BIT  = 40;
   localparam int unsigned AFF3_LSB  = 48;

   typedef struct packed {
      logic [INTID_W-1:0] intid;
      logic               bcast;
      logic [TLIST_W-1:0] tlist;
      logic [UPPER_W-1:0] upper;   // {level3, level2, level1}
   } sgi_req_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_SCAN = 2'd1,
      ST_DONE = 2'd2
   } scan_state_e;

endpackage

// File: rtl/sgi_req_decode.sv
module sgi_req_decode
   import sgi_fanout_pkg::*;
(
   input  logic [REQ_W-1:0] word,
   output sgi_req_t         req
);

   always_comb begin
      req.intid = word[INTID_LSB +: INTID_W];
      req.bcast = word[MODE_BIT];
      req.tlist = word[TLIST_LSB +: TLIST_W];
      req.upper = {word[AFF3_LSB +: LVL_W],
                   word[AFF2_LSB +: LVL_W],
                   word[AFF1_LSB +: LVL_W]};
   end

endmodule

// File: rtl/sgi_target_match.sv
module sgi_target_match
   import sgi_fanout_pkg::*;
#(
   parameter int unsigned NUM_CPUS = 8,
   parameter int unsigned IDX_W    = 3
)(
   input  logic [NUM_CPUS*AFF_W-1:0]        cpu_aff,
   input  logic [UPPER_W-1:0]               upper_q,
   input  logic                             bcast_q,
   input  logic [IDX_W-1:0]                 sender_q,
   input  logic [TLIST_W-1:0]               mask_q,
   output logic [NUM_CPUS-1:0]              sel_vec,
   output logic [NUM_CPUS-1:0][TLIST_W-1:0] l0_hot
);

   for (genvar g = 0; g < NUM_CPUS; g++) begin : g_cpu
      logic [AFF_W-1:0] aff;
      logic [LVL_W-1:0] lvl0;
      logic             in_range;
      logic             upper_eq;

      assign aff      = cpu_aff[g*AFF_W +: AFF_W];
      assign lvl0     = aff[LVL_W-1:0];
      assign in_range = (lvl0 < LVL_W'(TLIST_W));
      assign upper_eq = (aff[AFF_W-1:LVL_W] == upper_q);
      assign l0_hot[g] = in_range ? (TLIST_W'(1) << lvl0[TLIST_IDX_W-1:0])
                                  : '0;
      assign sel_vec[g] = bcast_q ? (sender_q != IDX_W'(g))
                                  : (upper_eq && (|(l0_hot[g] & mask_q)));
   end

endmodule

// File: rtl/sgi_scan_ctrl.sv
module sgi_scan_ctrl
   import sgi_fanout_pkg::*;
#(
   parameter int unsigned NUM_CPUS = 8,
   parameter int unsigned IDX_W    = 3
)(
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             req_valid,
   input  sgi_req_t                         req,
   input  logic [IDX_W-1:0]                 req_cpu,
   input  logic [NUM_CPUS-1:0]              sel_vec,
   input  logic [NUM_CPUS-1:0][TLIST_W-1:0] l0_hot,
   input  logic                             cmd_ready,
   output logic                             cmd_valid,
   output logic [IDX_W-1:0]                 cmd_cpu,
   output logic [INTID_W-1:0]               cmd_intid,
   output logic                             done,
   output logic                             busy,
   output logic [UPPER_W-1:0]               upper_q,
   output logic                             bcast_q,
   output logic [IDX_W-1:0]                 sender_q,
   output logic [TLIST_W-1:0]               mask_q
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CPUS - 1);

   scan_state_e        state_q;
   logic [IDX_W-1:0]   idx_q;
   logic [INTID_W-1:0] intid_q;

   logic               cur_sel;
   logic               advance;
   logic [TLIST_W-1:0] mask_nxt;
   logic               finish;

   always_comb begin
      cur_sel  = sel_vec[idx_q];
      advance  = (state_q == ST_SCAN) && (!cur_sel || cmd_ready);
      mask_nxt = (cur_sel && !bcast_q) ? (mask_q & ~l0_hot[idx_q]) : mask_q;
      finish   = (idx_q == LAST_IDX) || (!bcast_q && (mask_nxt == '0));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         idx_q    <= '0;
         intid_q  <= '0;
         bcast_q  <= 1'b0;
         mask_q   <= '0;
         upper_q  <= '0;
         sender_q <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  idx_q    <= '0;
                  intid_q  <= req.intid;
                  bcast_q  <= req.bcast;
                  mask_q   <= req.tlist;
                  upper_q  <= req.upper;
                  sender_q <= req_cpu;
                  state_q  <= (!req.bcast && (req.tlist == '0)) ? ST_DONE : ST_SCAN;
               end
            end
            ST_SCAN: begin
               if (advance) begin
                  mask_q <= mask_nxt;
                  if (finish) state_q <= ST_DONE;
                  else        idx_q   <= idx_q + IDX_W'(1);
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign cmd_valid = (state_q == ST_SCAN) && cur_sel;
   assign cmd_cpu   = idx_q;
   assign cmd_intid = intid_q;
   assign done      = (state_q == ST_DONE);
   assign busy      = (state_q != ST_IDLE);

   // R6
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_cpu) && $stable(cmd_intid)));

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

   // R7
   req_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(intid_q) && $stable(bcast_q) && $stable(sender_q) && $stable(upper_q)));

   // R5
   no_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && bcast_q) |-> (cmd_cpu != sender_q));

   // R3
   bit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready && !bcast_q) |=> ((mask_q & $past(l0_hot[idx_q])) == '0));

   // R4
   list_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_SCAN) && !bcast_q) |-> (mask_q != '0));

endmodule

// File: rtl/sgi_fanout.sv
module sgi_fanout
   import sgi_fanout_pkg::*;
#(
   parameter  int unsigned NUM_CPUS = 8,
   localparam int unsigned IDX_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
)(
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   input  logic [63:0]               req_word,
   input  logic [IDX_W-1:0]          req_cpu,
   input  logic [NUM_CPUS*32-1:0]    cpu_aff,
   output logic                      cmd_valid,
   input  logic                      cmd_ready,
   output logic [IDX_W-1:0]          cmd_cpu,
   output logic [3:0]                cmd_intid,
   output logic                      done,
   output logic                      busy
);

   if (NUM_CPUS < 1) begin : g_bad_count
      $error("sgi_fanout: NUM_CPUS must be at least 1");
   end
   if (AFF3_LSB + LVL_W > REQ_W || MODE_BIT >= REQ_W) begin : g_bad_fields
      $error("sgi_fanout: request field layout exceeds word width");
   end
   if (TLIST_W != (1 << TLIST_IDX_W)) begin : g_bad_list
      $error("sgi_fanout: target list width must be a power of two");
   end

   sgi_req_t                         req;
   logic [UPPER_W-1:0]               upper_q;
   logic                             bcast_q;
   logic [IDX_W-1:0]                 sender_q;
   logic [TLIST_W-1:0]               mask_q;
   logic [NUM_CPUS-1:0]              sel_vec;
   logic [NUM_CPUS-1:0][TLIST_W-1:0] l0_hot;

   sgi_req_decode u_decode (
      .word (req_word),
      .req  (req)
   );

   sgi_target_match #(
      .NUM_CPUS (NUM_CPUS),
      .IDX_W    (IDX_W)
   ) u_match (
      .cpu_aff  (cpu_aff),
      .upper_q  (upper_q),
      .bcast_q  (bcast_q),
      .sender_q (sender_q),
      .mask_q   (mask_q),
      .sel_vec  (sel_vec),
      .l0_hot   (l0_hot)
   );

   sgi_scan_ctrl #(
      .NUM_CPUS (NUM_CPUS),
      .IDX_W    (IDX_W)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req       (req),
      .req_cpu   (req_cpu),
      .sel_vec   (sel_vec),
      .l0_hot    (l0_hot),
      .cmd_ready (cmd_ready),
      .cmd_valid (cmd_valid),
      .cmd_cpu   (cmd_cpu),
      .cmd_intid (cmd_intid),
      .done      (done),
      .busy      (busy),
      .upper_q   (upper_q),
      .bcast_q   (bcast_q),
      .sender_q  (sender_q),
      .mask_q    (mask_q)
   );

endmodule

// File: tb/sgi_fanout_bench.sv
module sgi_fanout_bench;

   localparam int CLK_PERIOD = 10;
   localparam int N          = 6;
   localparam int IW         = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic [63:0]       req_word = '0;
   logic [IW-1:0]     req_cpu = '0;
   logic [N*32-1:0]   cpu_aff;
   logic              cmd_valid;
   logic              cmd_ready = 1'b1;
   logic [IW-1:0]     cmd_cpu;
   logic [3:0]        cmd_intid;
   logic              done;
   logic              busy;

   logic [31:0] aff [N];

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int ready_mode = 0;
   logic [15:0] lfsr = 16'hACE1;

   int exp_q[$];
   int got_q[$];

   // model state: 0 idle, 1 scanning, 2 done
   int          m_state = 0;
   int          m_idx = 0;
   logic [15:0] m_mask = '0;
   bit          m_bc = 0;
   int          m_send = 0;
   logic [3:0]  m_id = '0;
   logic [23:0] m_up = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sgi_fanout #(.NUM_CPUS(N)) u_sgi_fanout (
      .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_word (req_word),
      .req_cpu (req_cpu), .cpu_aff (cpu_aff), .cmd_valid (cmd_valid),
      .cmd_ready (cmd_ready), .cmd_cpu (cmd_cpu), .cmd_intid (cmd_intid),
      .done (done), .busy (busy)
   );

   initial begin
      aff[0] = 32'h0000_0000;
      aff[1] = 32'h0000_0001;
      aff[2] = 32'h0000_0002;
      aff[3] = 32'h0000_0100;
      aff[4] = 32'h0000_0101;
      aff[5] = 32'h0000_0114;
   end
   always_comb for (int c = 0; c < N; c++) cpu_aff[c*32 +: 32] = aff[c];

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic logic [63:0] mk(int id, bit bc, int tl, int a1, int a2, int a3);
      logic [63:0] w;
      w = '0;
      w[27:24] = id[3:0];
      w[15:0]  = tl[15:0];
      w[23:16] = a1[7:0];
      w[39:32] = a2[7:0];
      w[40]    = bc;
      w[55:48] = a3[7:0];
      return w;
   endfunction

   function automatic bit m_sel(int c);
      int l0;
      if (m_bc) return (c != m_send);
      l0 = int'(aff[c][7:0]);
      if (aff[c][31:8] != m_up) return 0;
      if (l0 >= 16) return 0;
      return m_mask[l0];
   endfunction

   // reference model, advanced on each rising edge
   always @(posedge clk) begin
      if (!rst_n) begin
         m_state = 0;
      end else begin
         case (m_state)
            0: if (req_valid) begin
                  m_id   = req_word[27:24];
                  m_bc   = req_word[40];
                  m_mask = req_word[15:0];
                  m_up   = {req_word[55:48], req_word[39:32], req_word[23:16]};
                  m_send = int'(req_cpu);
                  m_idx  = 0;
                  m_state = (!m_bc && m_mask == 0) ? 2 : 1;
               end
            1: begin
                  bit s;
                  s = m_sel(m_idx);
                  if (!s || cmd_ready) begin
                     if (s && !m_bc) m_mask[aff[m_idx][3:0]] = 1'b0;
                     if (m_idx == N-1 || (!m_bc && m_mask == 0)) m_state = 2;
                     else m_idx++;
                  end
               end
            default: m_state = 0;
         endcase
      end
   end

   // compare against the model every cycle
   always @(negedge clk) begin
      if (rst_n) begin
         bit ev;
         ev = (m_state == 1) && m_sel(m_idx);
         chk(cmd_valid == ev, "R2", "cmd_valid", longint'(cmd_valid), longint'(ev));
         if (ev) begin
            chk(int'(cmd_cpu) == m_idx, "R6", "cmd_cpu", longint'(cmd_cpu), longint'(m_idx));
            chk(cmd_intid == m_id, "R1", "cmd_intid", longint'(cmd_intid), longint'(m_id));
         end
         chk(done == (m_state == 2), "R9", "done", longint'(done), longint'(m_state == 2));
         chk(busy == (m_state != 0), "R7", "busy", longint'(busy), longint'(m_state != 0));
      end
   end

   // ready driver
   always @(negedge clk) begin
      #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cmd_ready = (ready_mode == 0) ? 1'b1 : lfsr[0];
   end

   // record accepted commands
   always @(negedge clk) begin
      #2;
      if (rst_n && cmd_valid && cmd_ready) got_q.push_back(int'(cmd_cpu));
   end

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000) begin
         errors++;
         $display("FAIL R9 watchdog: actual %0d cycles expected completion", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic build_exp(input logic [63:0] w, input int snd);
      logic [15:0] msk;
      exp_q.delete();
      msk = w[15:0];
      for (int c = 0; c < N; c++) begin
         if (w[40]) begin
            if (c != snd) exp_q.push_back(c);
         end else begin
            if (msk == 0) break;
            if (aff[c][31:8] == {w[55:48], w[39:32], w[23:16]} && aff[c][7:0] < 16
                && msk[aff[c][3:0]]) begin
               exp_q.push_back(c);
               msk[aff[c][3:0]] = 1'b0;
            end
         end
      end
   endtask

   task automatic run_req(input logic [63:0] w, input int snd, input int exp_busy,
                          input bit inject, input string tag);
      int cnt;
      build_exp(w, snd);
      got_q.delete();
      cnt = 0;
      @(negedge clk); #1;
      req_word = w; req_cpu = IW'(snd); req_valid = 1'b1;
      for (int t = 0; t < 2000; t++) begin
         @(negedge clk);
         if (busy) cnt++;
         if (t == 0) begin #1 req_valid = 1'b0; end
         if (inject && t == 2) begin
            #1 req_valid = 1'b1; req_word = mk(7, 0, 16'h0001, 1, 0, 0); req_cpu = '0;
         end
         if (inject && t == 3) begin #1 req_valid = 1'b0; end
         if (done) break;
      end
      @(negedge clk);
      chk(got_q.size() == exp_q.size(), tag, "command count",
          longint'(got_q.size()), longint'(exp_q.size()));
      for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
         chk(got_q[i] == exp_q[i], tag, "target order", longint'(got_q[i]), longint'(exp_q[i]));
      if (exp_busy >= 0)
         chk(cnt == exp_busy, tag, "busy cycles", longint'(cnt), longint'(exp_busy));
      chk(!busy, "R9", "idle after done", longint'(busy), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk(!busy, "R10", "busy after reset", longint'(busy), 0);
      chk(!done, "R10", "done after reset", longint'(done), 0);
      chk(!cmd_valid, "R10", "cmd_valid after reset", longint'(cmd_valid), 0);

      // R4 early stop after cpu2; cpus 3..5 never visited
      run_req(mk(5, 0, 16'h0005, 0, 0, 0), 1, 4, 0, "R4");
      // R3 list bits cleared, stop at cpu4
      run_req(mk(9, 0, 16'h0003, 1, 0, 0), 0, 6, 0, "R3");
      // R5 broadcast skips sender cpu2
      run_req(mk(3, 1, 16'h0000, 0, 0, 0), 2, 7, 0, "R5");
      // R7 request injected while busy is dropped
      run_req(mk(12, 1, 16'hFFFF, 9, 9, 9), 5, 7, 1, "R7");
      // R8 no match: full scan, no command
      run_req(mk(2, 0, 16'h0001, 7, 0, 0), 0, 7, 0, "R8");
      // R8 empty list: immediate done
      run_req(mk(2, 0, 16'h0000, 0, 0, 0), 0, 1, 0, "R8");
      // R2 level-2 mismatch selects nothing
      run_req(mk(4, 0, 16'hFFFF, 0, 1, 0), 3, 7, 0, "R2");
      // R2 level-0 of 20 cannot be addressed; list stays non-empty
      run_req(mk(6, 0, 16'hFFFF, 1, 0, 0), 3, 7, 0, "R2");
      // R1 top interrupt number, level-3 match on none
      run_req(mk(15, 0, 16'h0001, 0, 0, 1), 0, 7, 0, "R1");

      // R6 with backpressure
      ready_mode = 1;
      run_req(mk(15, 1, 16'h0000, 0, 0, 0), 0, -1, 0, "R6");
      run_req(mk(8, 0, 16'h0007, 0, 0, 0), 4, -1, 0, "R6");
      run_req(mk(1, 0, 16'h0003, 1, 0, 0), 4, -1, 0, "R6");
      ready_mode = 0;

      repeat (2) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule